// File: doc/BRIEF.md
# Twin-Predicated Element Stepper

The stepper walks a source element index and a destination element index through a vector operation. Each side has its own predicate mask. For every element move it offers one index pair to a datapath with one source and one destination, using a valid/ready handshake. The source index visits only the enabled source elements and the destination index visits only the enabled destination slots, each in ascending order. They are paired in that order. This one schedule covers several operations: with a full source mask it is an expand, and with a full destination mask it is a compress. With both masks sparse it performs ordered multiple inserts. A scalar source gives a splat, and a single-hot mask gives an insert or an extract.

A start pulse captures the whole configuration. That is the vector length, a predicate form and mask per side, a scalar/vector flag per side, and a mode bit. The mode bit selects single predication, where one mask drives both sides and both indices move together. After each accepted pair the stepper finds the next enabled element on each side with a priority encoder, so it can issue one pair per clock. When the walk is over it raises a one-cycle done pulse and returns to idle.

Top module: `twin_pred_stepper`

## Requirements
- R1: After reset, `pairValid`, `busy` and `done` are all low.
- R2: A `startIn` pulse while idle captures every configuration input and raises `busy`. A `startIn` pulse while busy, and any change on the configuration inputs during a run, have no effect on the pairs issued.
- R3: In twin mode with both sides vector, the n-th issued pair carries the n-th enabled source element below VL and the n-th enabled destination element below VL. Pairs stop when either side runs out. This gives expand, compress and ordered multiple insert.
- R4: In single mode (`singleModeIn`=1) only the source predicate is used. Each issued pair carries the next enabled element below VL, and every vector side reports that same element index.
- R5: Predicate form codes are 0 = all ones, 1 = the mask input (bit i enables element i), 2 = single-hot (1 shifted left by the shift input) and 3 = all ones. In single mode the destination predicate has no effect.
- R6: A scalar side always reports index 0 and never needs an enabled mask bit. In twin mode a scalar source with a vector destination repeats index 0 against every enabled destination slot.
- R7: With a scalar destination, the run ends after the first pair is accepted.
- R8: A run with VL = 0, or with no enabled element below VL on a vector side, issues no pair. Every issued index is below VL. `done` pulses for one cycle after the run ends, and `busy` is low in that cycle. No pair follows `done`.
- R9: While `pairValid` is high and `pairReady` is low, the next cycle keeps `pairValid` high with `srcStep` and `dstStep` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start pulse, taken only while idle |
| vlIn | input | $clog2(MAX_VL)+1 | Vector length, 0 to MAX_VL |
| singleModeIn | input | 1 | 1 = single predication, 0 = twin predication |
| srcVecIn | input | 1 | Source is a vector (1) or a scalar (0) |
| dstVecIn | input | 1 | Destination is a vector (1) or a scalar (0) |
| srcFormIn | input | 2 | Source predicate form code |
| srcMaskIn | input | MAX_VL | Source mask, bit i = element i |
| srcShiftIn | input | $clog2(MAX_VL) | Source single-hot position |
| dstFormIn | input | 2 | Destination predicate form code |
| dstMaskIn | input | MAX_VL | Destination mask, bit i = element i |
| dstShiftIn | input | $clog2(MAX_VL) | Destination single-hot position |
| pairValid | output | 1 | An index pair is offered |
| pairReady | input | 1 | Datapath accepts the offered pair |
| srcStep | output | $clog2(MAX_VL) | Source element index |
| dstStep | output | $clog2(MAX_VL) | Destination element index |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after a run ends |

## Verification
The bench builds the stepper with MAX_VL = 8. At that size an 8-bit mask covers every element, so full-length expand, compress and multiple-insert runs, single-hot positions inside and beyond VL, and the VL = 0 and VL = MAX_VL ends are all reachable with short vectors. Ready patterns with gaps exercise the hold rule in the middle of a walk. A second start pulse during a stalled run checks that the captured configuration cannot be disturbed.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  typedef enum logic [1:0] {
    PRED_ALL    = 2'd0,
    PRED_MASK   = 2'd1,
    PRED_ONEHOT = 2'd2,
    PRED_ALL_B  = 2'd3
  } predForm_e;

  typedef struct packed {
    logic load;
    logic advance;
  } ctrlStrobes_t;

endpackage

// File: rtl/stepper_pick.sv
module stepper_pick #(
  parameter int MAX_VL = 16
) (
  input  logic [MAX_VL-1:0]         maskIn,
  input  logic [$clog2(MAX_VL):0]   vlIn,
  input  logic [$clog2(MAX_VL):0]   posIn,
  output logic                      hitOut,
  output logic [$clog2(MAX_VL)-1:0] idxOut
);
  localparam int IDX_W = $clog2(MAX_VL);
  localparam int VL_W  = IDX_W + 1;

  // lowest enabled element at or above posIn and below vlIn
  always_comb begin
    hitOut = 1'b0;
    idxOut = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (maskIn[i] && (VL_W'(i) >= posIn) && (VL_W'(i) < vlIn)) begin
        hitOut = 1'b1;
        idxOut = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/stepper_dpath.sv
module stepper_dpath
  import stepper_pkg::*;
#(
  parameter int MAX_VL = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic                      pairValid,
  input  logic [$clog2(MAX_VL):0]   vlIn,
  input  logic                      singleModeIn,
  input  logic                      srcVecIn,
  input  logic                      dstVecIn,
  input  logic [1:0]                srcFormIn,
  input  logic [MAX_VL-1:0]         srcMaskIn,
  input  logic [$clog2(MAX_VL)-1:0] srcShiftIn,
  input  logic [1:0]                dstFormIn,
  input  logic [MAX_VL-1:0]         dstMaskIn,
  input  logic [$clog2(MAX_VL)-1:0] dstShiftIn,
  output logic                      avail,
  output logic                      dstIsVec,
  output logic [$clog2(MAX_VL)-1:0] srcStep,
  output logic [$clog2(MAX_VL)-1:0] dstStep
);
  localparam int IDX_W = $clog2(MAX_VL);
  localparam int VL_W  = IDX_W + 1;
  localparam int SIDES = 2;   // 0 = source, 1 = destination

  function automatic logic [MAX_VL-1:0] buildMask(
    input logic [1:0] formCode, input logic [MAX_VL-1:0] maskVal,
    input logic [IDX_W-1:0] shiftVal);
    case (predForm_e'(formCode))
      PRED_MASK:   return maskVal;
      PRED_ONEHOT: return MAX_VL'(1) << shiftVal;
      default:     return '1;
    endcase
  endfunction

  logic [MAX_VL-1:0] maskQ   [SIDES];
  logic [VL_W-1:0]   posQ    [SIDES];
  logic              vecQ    [SIDES];
  logic [VL_W-1:0]   vlQ;
  logic              singleQ;
  logic              pickHit [SIDES];
  logic [IDX_W-1:0]  pickIdx [SIDES];
  logic [IDX_W-1:0]  stepOut [SIDES];

  genvar g;
  for (g = 0; g < SIDES; g++) begin : g_side
    stepper_pick #(.MAX_VL(MAX_VL)) u_pick (
      .maskIn (maskQ[g]),
      .vlIn   (vlQ),
      .posIn  (posQ[g]),
      .hitOut (pickHit[g]),
      .idxOut (pickIdx[g])
    );
    // single mode routes the shared element to every vector side
    assign stepOut[g] = !vecQ[g] ? '0 : (singleQ ? pickIdx[0] : pickIdx[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vlQ     <= '0;
      singleQ <= 1'b0;
      for (int k = 0; k < SIDES; k++) begin
        maskQ[k] <= '0;
        posQ[k]  <= '0;
        vecQ[k]  <= 1'b0;
      end
    end else if (strobes.load) begin
      vlQ      <= vlIn;
      singleQ  <= singleModeIn;
      maskQ[0] <= buildMask(srcFormIn, srcMaskIn, srcShiftIn);
      maskQ[1] <= buildMask(dstFormIn, dstMaskIn, dstShiftIn);
      vecQ[0]  <= srcVecIn;
      vecQ[1]  <= dstVecIn;
      for (int k = 0; k < SIDES; k++) posQ[k] <= '0;
    end else if (strobes.advance) begin
      if (singleQ) begin
        posQ[0] <= VL_W'(pickIdx[0]) + VL_W'(1);
      end else begin
        for (int k = 0; k < SIDES; k++)
          if (vecQ[k]) posQ[k] <= VL_W'(pickIdx[k]) + VL_W'(1);
      end
    end
  end

  assign avail = (vlQ != '0) &&
                 (singleQ ? pickHit[0]
                          : ((pickHit[0] || !vecQ[0]) && (pickHit[1] || !vecQ[1])));
  assign dstIsVec = vecQ[1];
  assign srcStep  = stepOut[0];
  assign dstStep  = stepOut[1];

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> (VL_W'(srcStep) < vlQ) && (VL_W'(dstStep) < vlQ)); // R8
  AST_SINGLE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    pairValid && singleQ && vecQ[0] && vecQ[1] |-> srcStep == dstStep); // R4
  AST_SCALAR_SRC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    pairValid && !vecQ[0] |-> srcStep == '0); // R6
  AST_SRC_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance && vecQ[0] && !strobes.load |=> posQ[0] > $past(posQ[0])); // R3
endmodule

// File: rtl/stepper_ctrl.sv
module stepper_ctrl
  import stepper_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         avail,
  input  logic         dstIsVec,
  input  logic         pairReady,
  output logic         pairValid,
  output logic         busy,
  output logic         done,
  output ctrlStrobes_t strobes
);
  logic runQ;
  logic doneQ;
  logic fire;

  assign pairValid       = runQ && avail;
  assign fire            = pairValid && pairReady;
  assign strobes.load    = !runQ && startIn;
  assign strobes.advance = fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strobes.load) begin
        runQ <= 1'b1;
      end else if (runQ && (!avail || (fire && !dstIsVec))) begin
        runQ  <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  assign busy = runQ;
  assign done = doneQ;

  AST_DONE_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(runQ) && !runQ); // R8
  AST_SCALAR_DST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    fire && !dstIsVec |=> !runQ && doneQ); // R7
endmodule

// File: rtl/twin_pred_stepper.sv
module twin_pred_stepper
  import stepper_pkg::*;
#(
  parameter int MAX_VL = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startIn,
  input  logic [$clog2(MAX_VL):0]   vlIn,
  input  logic                      singleModeIn,
  input  logic                      srcVecIn,
  input  logic                      dstVecIn,
  input  logic [1:0]                srcFormIn,
  input  logic [MAX_VL-1:0]         srcMaskIn,
  input  logic [$clog2(MAX_VL)-1:0] srcShiftIn,
  input  logic [1:0]                dstFormIn,
  input  logic [MAX_VL-1:0]         dstMaskIn,
  input  logic [$clog2(MAX_VL)-1:0] dstShiftIn,
  output logic                      pairValid,
  input  logic                      pairReady,
  output logic [$clog2(MAX_VL)-1:0] srcStep,
  output logic [$clog2(MAX_VL)-1:0] dstStep,
  output logic                      busy,
  output logic                      done
);
  ctrlStrobes_t strobes;
  logic         avail;
  logic         dstIsVec;

  stepper_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .avail     (avail),
    .dstIsVec  (dstIsVec),
    .pairReady (pairReady),
    .pairValid (pairValid),
    .busy      (busy),
    .done      (done),
    .strobes   (strobes)
  );

  stepper_dpath #(.MAX_VL(MAX_VL)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .pairValid    (pairValid),
    .vlIn         (vlIn),
    .singleModeIn (singleModeIn),
    .srcVecIn     (srcVecIn),
    .dstVecIn     (dstVecIn),
    .srcFormIn    (srcFormIn),
    .srcMaskIn    (srcMaskIn),
    .srcShiftIn   (srcShiftIn),
    .dstFormIn    (dstFormIn),
    .dstMaskIn    (dstMaskIn),
    .dstShiftIn   (dstShiftIn),
    .avail        (avail),
    .dstIsVec     (dstIsVec),
    .srcStep      (srcStep),
    .dstStep      (dstStep)
  );

  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    pairValid && !pairReady |=> pairValid && $stable(srcStep) && $stable(dstStep)); // R9
endmodule

// File: tb/test_twin_pred_stepper.sv
module test_twin_pred_stepper;
  localparam int MAX_VL = 8;
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int NCASE  = 16;

  typedef struct packed {
    logic       single;
    logic       srcVec;
    logic       dstVec;
    logic [1:0] srcForm;
    logic [7:0] srcMask;
    logic [2:0] srcShift;
    logic [1:0] dstForm;
    logic [7:0] dstMask;
    logic [2:0] dstShift;
    logic [3:0] vl;
    logic [7:0] readyPat;
    logic [3:0] expCount;
    logic [31:0] expSrc;   // nibble n = source index of pair n
    logic [31:0] expDst;   // nibble n = destination index of pair n
  } caseVec_t;

  localparam caseVec_t CASES [NCASE] = '{
    '{1'b0,1'b1,1'b1,2'd0,8'h00,3'd0,2'd1,8'hA4,3'd0,4'd8,8'hFF,4'd3,32'h210,32'h752},   // expand R3
    '{1'b0,1'b1,1'b1,2'd1,8'h62,3'd0,2'd0,8'h00,3'd0,4'd8,8'hA6,4'd3,32'h651,32'h210},   // compress R3
    '{1'b0,1'b1,1'b1,2'd1,8'h99,3'd0,2'd1,8'h46,3'd0,4'd8,8'hFF,4'd3,32'h430,32'h621},   // multi-insert R3
    '{1'b0,1'b1,1'b1,2'd1,8'h99,3'd0,2'd1,8'h46,3'd0,4'd5,8'h5B,4'd2,32'h30,32'h21},     // VL cut R3
    '{1'b0,1'b0,1'b1,2'd0,8'h00,3'd0,2'd1,8'h49,3'd0,4'd7,8'hFF,4'd3,32'h000,32'h630},   // splat R6
    '{1'b0,1'b1,1'b0,2'd2,8'h00,3'd5,2'd0,8'h00,3'd0,4'd8,8'hFF,4'd1,32'h5,32'h0},       // extract R5
    '{1'b0,1'b0,1'b1,2'd0,8'h00,3'd0,2'd2,8'h00,3'd3,4'd8,8'h3C,4'd1,32'h0,32'h3},       // insert R5
    '{1'b1,1'b1,1'b1,2'd1,8'hCA,3'd0,2'd1,8'h01,3'd0,4'd8,8'hFF,4'd4,32'h7631,32'h7631}, // single R4
    '{1'b1,1'b0,1'b1,2'd1,8'h25,3'd0,2'd0,8'h00,3'd0,4'd6,8'h6D,4'd3,32'h0,32'h520},     // single scalar src R6
    '{1'b0,1'b1,1'b1,2'd0,8'h00,3'd0,2'd0,8'h00,3'd0,4'd0,8'hFF,4'd0,32'h0,32'h0},       // VL zero R8
    '{1'b0,1'b1,1'b1,2'd2,8'h00,3'd6,2'd0,8'h00,3'd0,4'd4,8'hFF,4'd0,32'h0,32'h0},       // hot beyond VL R8
    '{1'b1,1'b1,1'b1,2'd0,8'h00,3'd0,2'd0,8'h00,3'd0,4'd3,8'hFF,4'd3,32'h210,32'h210},   // single all R4
    '{1'b0,1'b1,1'b0,2'd1,8'h14,3'd0,2'd0,8'h00,3'd0,4'd8,8'hFF,4'd1,32'h2,32'h0},       // scalar dst R7
    '{1'b0,1'b0,1'b0,2'd0,8'h00,3'd0,2'd0,8'h00,3'd0,4'd3,8'hFF,4'd1,32'h0,32'h0},       // both scalar R7
    '{1'b1,1'b1,1'b0,2'd0,8'h00,3'd0,2'd0,8'h00,3'd0,4'd4,8'hFF,4'd1,32'h0,32'h0},       // single scalar dst R7
    '{1'b0,1'b1,1'b1,2'd3,8'h00,3'd0,2'd0,8'h00,3'd0,4'd2,8'hFF,4'd2,32'h10,32'h10}      // code 3 R5
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startIn = 1'b0;
  logic [IDX_W:0]   vlIn = '0;
  logic             singleModeIn = 1'b0;
  logic             srcVecIn = 1'b0;
  logic             dstVecIn = 1'b0;
  logic [1:0]       srcFormIn = '0;
  logic [MAX_VL-1:0] srcMaskIn = '0;
  logic [IDX_W-1:0] srcShiftIn = '0;
  logic [1:0]       dstFormIn = '0;
  logic [MAX_VL-1:0] dstMaskIn = '0;
  logic [IDX_W-1:0] dstShiftIn = '0;
  logic             pairValid;
  logic             pairReady = 1'b0;
  logic [IDX_W-1:0] srcStep;
  logic [IDX_W-1:0] dstStep;
  logic             busy;
  logic             done;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;

  twin_pred_stepper #(.MAX_VL(MAX_VL)) i_twin_pred_stepper (
    .clk(clk), .rstN(rstN), .startIn(startIn), .vlIn(vlIn),
    .singleModeIn(singleModeIn), .srcVecIn(srcVecIn), .dstVecIn(dstVecIn),
    .srcFormIn(srcFormIn), .srcMaskIn(srcMaskIn), .srcShiftIn(srcShiftIn),
    .dstFormIn(dstFormIn), .dstMaskIn(dstMaskIn), .dstShiftIn(dstShiftIn),
    .pairValid(pairValid), .pairReady(pairReady), .srcStep(srcStep),
    .dstStep(dstStep), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int idx);
    case (idx)
      0, 1, 2, 3:  return "R3";
      4, 8:        return "R6";
      5, 6, 15:    return "R5";
      7, 11:       return "R4";
      9, 10:       return "R8";
      default:     return "R7";
    endcase
  endfunction

  task automatic runCase(input caseVec_t c, input string req, input bit glitch);
    int got = 0;
    int gotSrc [8];
    int gotDst [8];
    bit gotDone = 1'b0;
    bit holdPend = 1'b0;
    int holdSrc = 0;
    int holdDst = 0;
    @(negedge clk);
    singleModeIn = c.single; srcVecIn = c.srcVec; dstVecIn = c.dstVec;
    srcFormIn = c.srcForm; srcMaskIn = c.srcMask; srcShiftIn = c.srcShift;
    dstFormIn = c.dstForm; dstMaskIn = c.dstMask; dstShiftIn = c.dstShift;
    vlIn = c.vl; startIn = 1'b1; pairReady = 1'b0;
    for (int iter = 0; iter < 60; iter++) begin
      @(negedge clk);
      startIn = 1'b0;
      if (glitch && iter == 2) begin
        // R2: second start and altered inputs during a run
        startIn = 1'b1; singleModeIn = 1'b1; srcFormIn = 2'd0;
        dstFormIn = 2'd0; dstVecIn = 1'b0; vlIn = 4'd8;
      end
      pairReady = c.readyPat[iter % 8];
      #1;
      if (holdPend) begin
        check(pairValid && srcStep == IDX_W'(holdSrc) && dstStep == IDX_W'(holdDst),
              "R9", "held pair src", int'(srcStep), holdSrc);
      end
      if (done) begin
        gotDone = 1'b1;
        check(!busy && !pairValid, "R8", "idle at done", int'(busy), 0);
        break;
      end
      if (pairValid && pairReady) begin
        if (got < 8) begin
          gotSrc[got] = int'(srcStep);
          gotDst[got] = int'(dstStep);
        end
        got++;
      end
      holdPend = pairValid && !pairReady;
      holdSrc = int'(srcStep);
      holdDst = int'(dstStep);
    end
    startIn = 1'b0;
    pairReady = 1'b0;
    check(gotDone, "R8", "done seen", int'(gotDone), 1);
    check(got == int'(c.expCount), req, "pair count", got, int'(c.expCount));
    for (int n = 0; n < 8; n++) begin
      if (n < got && n < int'(c.expCount)) begin
        check(gotSrc[n] == int'(c.expSrc[n*4 +: 4]), req, "source index",
              gotSrc[n], int'(c.expSrc[n*4 +: 4]));
        check(gotDst[n] == int'(c.expDst[n*4 +: 4]), req, "destination index",
              gotDst[n], int'(c.expDst[n*4 +: 4]));
      end
    end
    @(negedge clk);
    #1;
    check(!done && !busy && !pairValid, "R8", "quiet after done",
          int'(done) + int'(busy) + int'(pairValid), 0);
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!pairValid && !busy && !done, "R1", "reset outputs",
          int'(pairValid) + int'(busy) + int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(!pairValid && !busy && !done, "R1", "idle after reset release",
          int'(pairValid) + int'(busy) + int'(done), 0);

    for (int i = 0; i < NCASE; i++) runCase(CASES[i], reqOf(i), 1'b0);

    // R2: compress run with a stalled start disturbed mid-walk
    runCase(CASES[1], "R2", 1'b1);

    // R2: busy rises right after an accepted start
    @(negedge clk);
    vlIn = 4'd4; singleModeIn = 1'b0; srcVecIn = 1'b1; dstVecIn = 1'b1;
    srcFormIn = 2'd0; dstFormIn = 2'd0; startIn = 1'b1; pairReady = 1'b0;
    @(negedge clk);
    startIn = 1'b0;
    #1;
    check(busy && pairValid && srcStep == 0 && dstStep == 0, "R2", "busy after start",
          int'(busy), 1);
    pairReady = 1'b1;
    repeat (6) @(negedge clk);
    pairReady = 1'b0;
    #1;
    check(!busy, "R8", "run finished", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule